// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns a product of `2*WIDTH` bits. It examines one bit of the multiplier per clock cycle, so a full multiply takes `WIDTH` cycles. A pulse on `start` loads the operands. `busy` stays high while the block accumulates, and `done` pulses for one cycle when the product is final.

The datapath holds three registers. The multiplicand sits in a register of double width that moves one place left every cycle. The multiplier sits in a `WIDTH`-bit register that moves one place right, so its bit 0 is always the bit being processed. The third register is the product, which stays in place. A two-way selector passes either the shifted multiplicand or zero to a `2*WIDTH`-bit adder. The adder result goes back into the product register. After step i, the product register holds the sum of A·b(j)·2^j for j < i.

The controller has three states. `ST_IDLE` waits for `start`. `ST_RUN` accumulates once per cycle. `ST_DONE` lasts one cycle and raises `done`. The transitions are:
- load: `ST_IDLE` or `ST_DONE` to `ST_RUN`, on `start`.
- step: `ST_RUN` to `ST_RUN`, while steps remain.
- finish: `ST_RUN` to `ST_DONE`, after the last step.
- settle: `ST_DONE` to `ST_IDLE`, when `start` is low.
- wait: `ST_IDLE` to `ST_IDLE`, when `start` is low.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high in `ST_IDLE` or `ST_DONE` captures `op_a` and `op_b`. In the following cycle `busy` is 1 and `product` is 0.
- R3: When `done` is 1, `product` equals op_a × op_b, taken as unsigned values, over the full `2*WIDTH` bits.
- R4: `busy` stays high for exactly `WIDTH` cycles after the load edge. `done` is high in the cycle right after those `WIDTH` cycles. `busy` and `done` are never high together.
- R5: `done` is high for one cycle only.
- R6: While `busy` is low and `start` is low, `product` does not change. The result therefore stays readable until the next load.
- R7: A `start` that arrives while `busy` is high is ignored. The operands are not sampled again and the completion time does not move.
- R8: After k accumulation steps (1 ≤ k ≤ `WIDTH`), `product` equals op_a × (op_b mod 2^k). The value never decreases while a multiply runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the operands and begin a multiply |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: the product is final |
| product | output | 2*WIDTH | Product register |

## Verification
The hardest case to reach from the ports is a second `start` that lands while a multiply is running, with different operands on the inputs. If this start were wrongly accepted, it would reload the operands or restart the step count. The bench therefore raises `start` with the inverted operands part way through some multiplies, and checks both the final product and the cycle in which `done` rises. A second hard case is a load in the same cycle as the `done` pulse. The bench reaches it by chaining two multiplies with no idle cycle between them. Every pair of 4-bit operands is swept, and the partial product is checked after every step.

// File: rtl/mul_pkg.sv
package mul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    import mul_pkg::*;

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    mul_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-state logic for the load, step, finish, settle and wait transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST_STEP) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register together with the step counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_RUN) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output decode from the current state.
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
                load = start;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mul_addend_sel.sv
module mul_addend_sel #(
    parameter int DW = 8
) (
    input  logic          pick,
    input  logic [DW-1:0] shifted_a,
    output logic [DW-1:0] addend
);
    always_comb addend = pick ? shifted_a : '0;
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   b_in,
    output logic [2*WIDTH-1:0] acc
);
    localparam int DW = 2 * WIDTH;

    logic [DW-1:0]    mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic [DW-1:0]    addend;
    logic [DW-1:0]    sum;

    mul_addend_sel #(.DW(DW)) u_sel (
        .pick      (mplier_q[0]),
        .shifted_a (mcand_q),
        .addend    (addend)
    );

    always_comb sum = acc + addend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
            acc      <= '0;
        end else if (load) begin
            mcand_q  <= {{WIDTH{1'b0}}, a_in};
            mplier_q <= b_in;
            acc      <= '0;
        end else if (step) begin
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
            acc      <= sum;
        end
    end
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic load;
    logic step;

    mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    mul_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .a_in  (op_a),
        .b_in  (op_b),
        .acc   (product)
    );
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);
    localparam int RUN_W = $clog2(WIDTH + 1) + 1;

    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R1
    always @(posedge clk) if (!rst_n) reset_state_chk: assert (!busy && !done && product == '0);

    // R2
    load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && product == '0));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RUN_W'(WIDTH)));

    // R4
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == RUN_W'(WIDTH)));

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));

    // R8
    monotonic_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (product >= $past(product)));
endmodule

bind shift_add_mul mul_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/shift_add_mul_bench.sv
module shift_add_mul_bench;
    localparam int W  = 4;
    localparam int DW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          busy;
    logic          done;
    logic [DW-1:0] product;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    shift_add_mul #(.WIDTH(W)) u_shift_add_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .product(product)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Call just after a negedge. Leaves the caller at the negedge where done is high,
    // or at the negedge one cycle later if chain is 0.
    task automatic run_mul(input int a, input int b, input bit inject, input bit chain);
        longint exp_full;
        longint exp_part;
        longint held;
        exp_full = longint'(a) * longint'(b);
        op_a  = W'(a);
        op_b  = W'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after load", busy, 1);
        check(product == '0, "R2 product cleared", product, 0);
        for (int k = 1; k <= W; k++) begin
            if (inject && k == 1) begin
                op_a  = ~W'(a);
                op_b  = ~W'(b);
                start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            exp_part = longint'(a) * longint'(b % (1 << k));
            check(product == DW'(exp_part), "R8 partial product", product, exp_part);
            check(busy == (k < W), "R4 busy window", busy, (k < W));
            check(done == (k == W), "R4 done timing", done, (k == W));
        end
        check(product == DW'(exp_full), inject ? "R7 product with ignored start" : "R3 product",
              product, exp_full);
        if (!chain) begin
            held = product;
            @(negedge clk);
            check(done == 1'b0, "R5 done single cycle", done, 0);
            check(product == DW'(held), "R6 product held", product, held);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog expired actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy == 1'b0, "R1 busy at reset", busy, 0);
        check(done == 1'b0, "R1 done at reset", done, 0);
        check(product == '0, "R1 product at reset", product, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(product == '0 && !busy, "R1 idle after reset", product, 0);

        // R3 R8: exhaustive sweep, including 0*x, 1*x and all-ones*all-ones
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_mul(a, b, 1'b0, 1'b0);
            end
        end

        // R7: start raised during busy with inverted operands
        for (int a = 0; a < (1 << W); a += 3) begin
            run_mul(a, (1 << W) - 1 - a, 1'b1, 1'b0);
        end

        // R6: idle for several cycles, product must hold
        begin
            longint held;
            held = product;
            repeat (5) @(negedge clk);
            check(product == DW'(held) && !busy && !done, "R6 long idle hold", product, held);
        end

        // R2: load accepted in the done cycle (back-to-back)
        run_mul(7, 9, 1'b0, 1'b1);
        run_mul(15, 15, 1'b0, 1'b1);
        run_mul(1, 13, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule